// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block turns a 32-bit virtual address into a physical address by reading two page table entries, one after the other, from memory. The caller supplies a virtual address together with the physical base address of the top-level table. The walker takes the upper ten address bits to pick a directory entry in that table. If that entry is valid, it takes the next ten bits to pick a leaf entry in the second-level table the directory entry points to. A valid leaf yields the physical frame number and its access-right bits. The low twelve bits of the virtual address pass through unchanged.

The walk can stop with a page fault at either level. A directory entry with its valid bit clear ends the walk after one read. A leaf entry with its valid bit clear ends it after two reads. In both cases the result is reported as a one-cycle pulse that carries the faulting virtual address. The walker handles one translation at a time. Its memory side is a plain word-read port with a valid/ready request and a response strobe.

Top module: `ptw_walker`

## Requirements
- R1: `req_ready` is high only while the walker is idle. A request is taken at a clock edge where `req_valid` and `req_ready` are both high, and `req_vaddr` and `table_root` are captured at that edge. Request inputs presented while the walker is busy have no effect on the walk.
- R2: The first memory read goes to `table_root + vaddr[31:22] * 4`, wrapping at 32 bits.
- R3: The second memory read goes to `{dir[31:12], 12'h000} + vaddr[21:12] * 4`, where `dir` is the directory entry returned by the first read.
- R4: Entry layout: bit 0 is the valid flag, bits 3:1 are the access rights, bits 11:4 are ignored, and bits 31:12 are the frame number. A directory entry with bit 0 clear ends the walk with a fault, and no second read is issued.
- R5: A leaf entry with bit 0 clear ends the walk with a fault after exactly two reads.
- R6: A memory request keeps `mem_req_valid` high and `mem_req_addr` stable until `mem_req_ready` is seen. At most one read is outstanding. `mem_rsp_valid` has no effect while no read is awaited.
- R7: On success, `done` rises exactly one cycle after the clock edge that takes the leaf response and stays high for one cycle. At that point `paddr = {leaf[31:12], vaddr[11:0]}` and `rights = leaf[3:1]`; the directory entry's rights bits are ignored.
- R8: On a fault, `done` and `fault` are high together for one cycle, exactly one cycle after the edge that takes the invalid entry. `fault_vaddr` equals the captured virtual address, and `paddr` and `rights` are zero.
- R9: When `done` is low, `fault`, `paddr`, `rights` and `fault_vaddr` are all zero. After reset, `req_ready` is 1 and `mem_req_valid` and `done` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Translation request strobe |
| req_ready | output | 1 | Walker is idle and can take a request |
| req_vaddr | input | 32 | Virtual address to translate |
| table_root | input | 32 | Physical base address of the top-level table |
| mem_req_valid | output | 1 | Word read request to memory |
| mem_req_ready | input | 1 | Memory takes the read request |
| mem_req_addr | output | 32 | Byte address of the entry to read |
| mem_rsp_valid | input | 1 | Read data is present |
| mem_rsp_data | input | 32 | Entry word returned by memory |
| done | output | 1 | One-cycle completion pulse |
| fault | output | 1 | The completed walk ended in a page fault |
| fault_vaddr | output | 32 | Virtual address that faulted |
| paddr | output | 32 | Translated physical address |
| rights | output | 3 | Access-right bits from the leaf entry |

## Verification
The bound checker watches, on every cycle, that the request port is ready only when no read or result is pending. It also checks that a stalled memory request holds its address, that completion follows a final response by exactly one cycle as a single pulse, and that result outputs stay zero outside that pulse and are zero on a fault. Some properties need knowledge of the table contents. These are the read addresses computed from the indices, the frame/offset join, the choice of leaf rights over directory rights, the number of reads per walk, and immunity to stray responses and to requests made while busy. Only the bench's scenarios show these, by setting up entries in a memory model and comparing each read and each result with its own arithmetic.

// File: rtl/ptw_pkg.sv
`timescale 1ns/1ps
package ptw_pkg;
  localparam int unsigned PTW_OFF_W    = 12;
  localparam int unsigned PTW_IDX_W    = 10;
  localparam int unsigned PTW_VA_W     = 2 * PTW_IDX_W + PTW_OFF_W;
  localparam int unsigned PTW_PA_W     = 32;
  localparam int unsigned PTW_PTE_W    = 32;
  localparam int unsigned PTW_RIGHTS_W = 3;
  localparam int unsigned PTW_PPN_W    = PTW_PA_W - PTW_OFF_W;
  localparam int unsigned PTW_ENTRY_SH = $clog2(PTW_PTE_W / 8);

  typedef enum logic [2:0] {
    ST_IDLE, ST_DIR_REQ, ST_DIR_WAIT, ST_LEAF_REQ, ST_LEAF_WAIT, ST_RESP
  } ptw_state_e;

  function automatic logic [PTW_IDX_W-1:0] top_index(input logic [PTW_VA_W-1:0] va);
    return va[PTW_VA_W-1 -: PTW_IDX_W];
  endfunction

  function automatic logic [PTW_IDX_W-1:0] leaf_index(input logic [PTW_VA_W-1:0] va);
    return va[PTW_OFF_W +: PTW_IDX_W];
  endfunction

  function automatic logic [PTW_OFF_W-1:0] page_offset(input logic [PTW_VA_W-1:0] va);
    return va[PTW_OFF_W-1:0];
  endfunction

  function automatic logic [PTW_PA_W-1:0] frame_base(input logic [PTW_PPN_W-1:0] ppn);
    return {ppn, {PTW_OFF_W{1'b0}}};
  endfunction

  function automatic logic [PTW_PA_W-1:0] entry_addr(input logic [PTW_PA_W-1:0] tbl,
                                                     input logic [PTW_IDX_W-1:0] idx);
    return tbl + (PTW_PA_W'(idx) << PTW_ENTRY_SH);
  endfunction

  function automatic logic [PTW_PA_W-1:0] join_pa(input logic [PTW_PPN_W-1:0] ppn,
                                                  input logic [PTW_OFF_W-1:0] off);
    return {ppn, off};
  endfunction
endpackage

// File: rtl/ptw_pte_decode.sv
`timescale 1ns/1ps
module ptw_pte_decode
  import ptw_pkg::*;
(
  input  logic [PTW_PTE_W-1:0]    raw,
  output logic                    ok,
  output logic [PTW_RIGHTS_W-1:0] perm,
  output logic [PTW_PPN_W-1:0]    ppn
);
  always_comb begin
    ok   = raw[0];
    perm = raw[PTW_RIGHTS_W:1];
    ppn  = raw[PTW_PTE_W-1 -: PTW_PPN_W];
  end
endmodule

// File: rtl/ptw_addr_gen.sv
`timescale 1ns/1ps
module ptw_addr_gen
  import ptw_pkg::*;
(
  input  logic                 use_leaf,
  input  logic [PTW_VA_W-1:0]  vaddr,
  input  logic [PTW_PA_W-1:0]  root,
  input  logic [PTW_PPN_W-1:0] dir_ppn,
  output logic [PTW_PA_W-1:0]  addr
);
  logic [PTW_PA_W-1:0] dir_addr;
  logic [PTW_PA_W-1:0] leaf_addr;

  always_comb begin
    dir_addr  = entry_addr(root, top_index(vaddr));
    leaf_addr = entry_addr(frame_base(dir_ppn), leaf_index(vaddr));
    addr      = use_leaf ? leaf_addr : dir_addr;
  end
endmodule

// File: rtl/ptw_fsm.sv
`timescale 1ns/1ps
module ptw_fsm
  import ptw_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       req_valid,
  input  logic       mem_req_ready,
  input  logic       mem_rsp_valid,
  input  logic       pte_ok,
  output ptw_state_e st,
  output logic       ev_accept,
  output logic       ev_issue,
  output logic       ev_l1_rsp,
  output logic       ev_l2_rsp
);
  ptw_state_e st_nx;

  always_comb begin
    ev_accept = (st == ST_IDLE) && req_valid;
    ev_issue  = ((st == ST_DIR_REQ) || (st == ST_LEAF_REQ)) && mem_req_ready;
    ev_l1_rsp = (st == ST_DIR_WAIT) && mem_rsp_valid;
    ev_l2_rsp = (st == ST_LEAF_WAIT) && mem_rsp_valid;
  end

  always_comb begin
    st_nx = st;
    unique case (st)
      ST_IDLE:      if (ev_accept) st_nx = ST_DIR_REQ;
      ST_DIR_REQ:   if (ev_issue)  st_nx = ST_DIR_WAIT;
      ST_DIR_WAIT:  if (ev_l1_rsp) st_nx = pte_ok ? ST_LEAF_REQ : ST_RESP;
      ST_LEAF_REQ:  if (ev_issue)  st_nx = ST_LEAF_WAIT;
      ST_LEAF_WAIT: if (ev_l2_rsp) st_nx = ST_RESP;
      ST_RESP:      st_nx = ST_IDLE;
      default:      st_nx = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) st <= ST_IDLE;
    else        st <= st_nx;
  end
endmodule

// File: rtl/ptw_walker.sv
`timescale 1ns/1ps
module ptw_walker
  import ptw_pkg::*;
(
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    req_valid,
  output logic                    req_ready,
  input  logic [PTW_VA_W-1:0]     req_vaddr,
  input  logic [PTW_PA_W-1:0]     table_root,
  output logic                    mem_req_valid,
  input  logic                    mem_req_ready,
  output logic [PTW_PA_W-1:0]     mem_req_addr,
  input  logic                    mem_rsp_valid,
  input  logic [PTW_PTE_W-1:0]    mem_rsp_data,
  output logic                    done,
  output logic                    fault,
  output logic [PTW_VA_W-1:0]     fault_vaddr,
  output logic [PTW_PA_W-1:0]     paddr,
  output logic [PTW_RIGHTS_W-1:0] rights
);
  ptw_state_e st;
  logic ev_accept, ev_issue, ev_l1_rsp, ev_l2_rsp;
  logic pte_ok;
  logic [PTW_RIGHTS_W-1:0] pte_perm;
  logic [PTW_PPN_W-1:0]    pte_ppn;

  logic [PTW_VA_W-1:0]     vaddr_q;
  logic [PTW_PA_W-1:0]     root_q;
  logic [PTW_PPN_W-1:0]    dir_ppn_q;
  logic [PTW_PPN_W-1:0]    leaf_ppn_q;
  logic [PTW_RIGHTS_W-1:0] perm_q;
  logic                    fault_q;

  ptw_fsm u_fsm (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid),
    .mem_req_ready(mem_req_ready), .mem_rsp_valid(mem_rsp_valid),
    .pte_ok(pte_ok), .st(st), .ev_accept(ev_accept), .ev_issue(ev_issue),
    .ev_l1_rsp(ev_l1_rsp), .ev_l2_rsp(ev_l2_rsp)
  );

  ptw_pte_decode u_dec (
    .raw(mem_rsp_data), .ok(pte_ok), .perm(pte_perm), .ppn(pte_ppn)
  );

  ptw_addr_gen u_agen (
    .use_leaf(st == ST_LEAF_REQ), .vaddr(vaddr_q), .root(root_q),
    .dir_ppn(dir_ppn_q), .addr(mem_req_addr)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vaddr_q    <= '0;
      root_q     <= '0;
      dir_ppn_q  <= '0;
      leaf_ppn_q <= '0;
      perm_q     <= '0;
      fault_q    <= 1'b0;
    end else begin
      if (ev_accept) begin
        vaddr_q <= req_vaddr;
        root_q  <= table_root;
        fault_q <= 1'b0;
      end
      if (ev_l1_rsp && pte_ok) dir_ppn_q <= pte_ppn;
      if (ev_l2_rsp && pte_ok) begin
        leaf_ppn_q <= pte_ppn;
        perm_q     <= pte_perm;
      end
      if ((ev_l1_rsp || ev_l2_rsp) && !pte_ok) fault_q <= 1'b1;
    end
  end

  always_comb begin
    req_ready     = (st == ST_IDLE);
    mem_req_valid = (st == ST_DIR_REQ) || (st == ST_LEAF_REQ);
    done          = (st == ST_RESP);
    fault         = done && fault_q;
    fault_vaddr   = (done && fault_q) ? vaddr_q : '0;
    paddr         = (done && !fault_q) ? join_pa(leaf_ppn_q, page_offset(vaddr_q)) : '0;
    rights        = (done && !fault_q) ? perm_q : '0;
  end
endmodule

// File: rtl/ptw_walker_chk.sv
`timescale 1ns/1ps
module ptw_walker_chk
  import ptw_pkg::*;
(
  input logic                    clk,
  input logic                    rst_n,
  input logic                    req_ready,
  input logic                    mem_req_valid,
  input logic                    mem_req_ready,
  input logic [PTW_PA_W-1:0]     mem_req_addr,
  input logic                    done,
  input logic                    fault,
  input logic [PTW_VA_W-1:0]     fault_vaddr,
  input logic [PTW_PA_W-1:0]     paddr,
  input logic [PTW_RIGHTS_W-1:0] rights,
  input logic                    ev_accept,
  input logic                    ev_l1_rsp,
  input logic                    ev_l2_rsp,
  input logic                    pte_ok
);
  a_r1_ready_means_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (!mem_req_valid && !done));

  a_r1_accept_starts_read: assert property (@(posedge clk) disable iff (!rst_n)
    ev_accept |=> mem_req_valid);

  a_r6_request_held: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_req_addr)));

  a_r4_dir_fault_ends: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_l1_rsp && !pte_ok) |=> (done && fault && !mem_req_valid));

  a_r7_leaf_then_done: assert property (@(posedge clk) disable iff (!rst_n)
    ev_l2_rsp |=> done);

  a_r7_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  a_r8_fault_no_address: assert property (@(posedge clk) disable iff (!rst_n)
    fault |-> (paddr == '0 && rights == '0));

  a_r9_quiet_outputs: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> (!fault && paddr == '0 && rights == '0 && fault_vaddr == '0));
endmodule

bind ptw_walker ptw_walker_chk u_chk (.*);

// File: tb/tb_ptw_walker.sv
`timescale 1ns/1ps
module tb_ptw_walker;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [31:0] req_vaddr = '0;
  logic [31:0] table_root = '0;
  logic        mem_req_valid;
  logic        mem_req_ready = 1'b0;
  logic [31:0] mem_req_addr;
  logic        mem_rsp_valid = 1'b0;
  logic [31:0] mem_rsp_data = '0;
  logic        done, fault;
  logic [31:0] fault_vaddr, paddr;
  logic [2:0]  rights;

  always #2.5 clk = ~clk;

  ptw_walker dut (.*);

  logic [31:0] mem [logic [31:0]];
  int checks = 0, fails = 0, cyc = 0;
  int lat = 1, rmode = 0;
  bit running = 0, spur = 0, exp_done = 0, done_seen = 0;
  bit exp_fault = 0;
  logic [31:0] exp_pa = '0, exp_fva = '0;
  logic [2:0]  exp_rt = '0;
  logic [31:0] exp_addr_q[$];
  int          due_q[$];
  logic [31:0] dat_q[$];
  int rsp_in_walk = 0, walk_reads = 0;

  function automatic logic [31:0] rd(input logic [31:0] a);
    return mem.exists(a) ? mem[a] : 32'h0;
  endfunction

  function automatic logic [31:0] mk(input int frame, input int rt, input int v);
    return (frame * 4096) + 32'h0000_0A50 + (rt * 2) + v;
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (running) begin
      cyc++;
      if (cyc > 150000) begin
        checks++; fails++;
        $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
      end
      chk(done === exp_done, exp_fault ? "R8" : "R7", "done timing", 32'(done), 32'(exp_done));
      if (done) begin
        done_seen = 1;
        chk(fault === exp_fault, "R8", "fault flag", 32'(fault), 32'(exp_fault));
        if (exp_fault) begin
          chk(fault_vaddr === exp_fva, "R8", "fault_vaddr", fault_vaddr, exp_fva);
          chk(paddr === 0 && rights === 0, "R8", "paddr zero", paddr, 0);
        end else begin
          chk(paddr === exp_pa, "R7", "paddr", paddr, exp_pa);
          chk(rights === exp_rt, "R7", "rights", 32'(rights), 32'(exp_rt));
        end
      end else begin
        chk(fault === 0 && paddr === 0 && rights === 0 && fault_vaddr === 0,
            "R9", "idle outputs", paddr | fault_vaddr | 32'(rights) | 32'(fault), 0);
      end
      exp_done = 0;
      mem_rsp_valid = 0;
      mem_rsp_data = '0;
      if (due_q.size() > 0 && due_q[0] == cyc) begin
        logic [31:0] d;
        void'(due_q.pop_front());
        d = dat_q.pop_front();
        mem_rsp_valid = 1;
        mem_rsp_data = d;
        rsp_in_walk++;
        if (rsp_in_walk == 2 || d[0] == 1'b0) exp_done = 1;
      end else if (spur) begin
        mem_rsp_valid = 1;
        mem_rsp_data = 32'hFFFF_F00F;
      end
      mem_req_ready = (rmode == 0) ? 1'b1 : (cyc % 3 == 0);
      if (mem_req_valid && mem_req_ready) begin
        walk_reads++;
        if (exp_addr_q.size() == 0) begin
          chk(0, "R6", "unexpected read", mem_req_addr, 0);
        end else begin
          logic [31:0] e;
          e = exp_addr_q.pop_front();
          chk(mem_req_addr === e, (walk_reads == 1) ? "R2" : "R3", "read address", mem_req_addr, e);
        end
        due_q.push_back(cyc + lat);
        dat_q.push_back(rd(mem_req_addr));
      end
    end
  end

  task automatic walk(input logic [31:0] va, input logic [31:0] base,
                      input int l, input int rm, input bit poke);
    logic [31:0] a1, e1, a2, e2;
    int n_reads;
    a1 = base + (va / 32'd4194304) * 4;
    e1 = rd(a1);
    exp_addr_q.delete();
    exp_addr_q.push_back(a1);
    exp_fva = va;
    if (e1 % 2 == 0) begin
      n_reads = 1; exp_fault = 1; exp_pa = 0; exp_rt = 0;
    end else begin
      a2 = (e1 / 4096) * 4096 + ((va / 4096) % 1024) * 4;
      e2 = rd(a2);
      exp_addr_q.push_back(a2);
      n_reads = 2;
      if (e2 % 2 == 0) begin
        exp_fault = 1; exp_pa = 0; exp_rt = 0;
      end else begin
        exp_fault = 0;
        exp_pa = (e2 / 4096) * 4096 + (va % 4096);
        exp_rt = 3'((e2 / 2) % 8);
      end
    end
    lat = l; rmode = rm;
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    walk_reads = 0; rsp_in_walk = 0; done_seen = 0;
    req_valid = 1; req_vaddr = va; table_root = base;
    @(negedge clk);
    req_valid = 0; req_vaddr = ~va; table_root = ~base;
    if (poke) begin
      req_valid = 1; req_vaddr = 32'h0080_0000;
      chk(req_ready === 1'b0, "R1", "busy ready", 32'(req_ready), 0);
      @(negedge clk);
      req_valid = 0;
    end
    wait (done_seen);
    chk(walk_reads == n_reads, (n_reads == 1) ? "R4" : "R5", "read count", walk_reads, n_reads);
  endtask

  localparam logic [31:0] B1 = 32'h0010_0000;
  localparam logic [31:0] B2 = 32'h0100_0000;

  initial begin
    mem[B1 + 32'h4]        = mk(32'h00200, 7, 1);
    mem[32'h0020_000C]     = mk(32'h12345, 5, 1);
    mem[B1 + 32'hFFC]      = mk(32'h00300, 0, 1);
    mem[32'h0030_0FFC]     = mk(32'hFEDCB, 3, 1);
    mem[B1]                = mk(32'h00400, 0, 1);
    mem[32'h0040_0000]     = mk(32'h00001, 1, 1);
    mem[B1 + 32'h8]        = mk(32'h00500, 7, 0);
    mem[32'h0020_0014]     = mk(32'h77777, 7, 0);
    mem[B2 + 32'h4]        = mk(32'h00600, 0, 1);
    mem[32'h0060_000C]     = mk(32'h0ABCD, 6, 1);

    repeat (4) @(negedge clk);
    chk(req_ready === 1'b1, "R9", "reset ready", 32'(req_ready), 1);
    chk(mem_req_valid === 1'b0, "R9", "reset mem_req_valid", 32'(mem_req_valid), 0);
    chk(done === 1'b0, "R9", "reset done", 32'(done), 0);
    rst_n = 1;
    running = 1;

    walk(32'h0040_3ABC, B1, 1, 0, 0);   // R7 basic, dir rights ignored
    walk(32'h0040_3ABC, B1, 3, 1, 0);   // R6 stalled request, longer latency
    walk(32'hFFFF_FFFF, B1, 1, 0, 0);   // R2 R3 top indices
    walk(32'h0000_0000, B1, 2, 1, 0);   // R2 R3 zero indices
    walk(32'h0080_0123, B1, 1, 0, 0);   // R4 directory fault
    walk(32'h0040_5000, B1, 2, 1, 0);   // R5 leaf fault
    walk(32'h0040_3ABC, B1, 1, 0, 1);   // R1 request while busy
    spur = 1;                           // R6 stray responses while idle
    repeat (5) @(negedge clk);
    spur = 0;
    walk(32'h0040_3ABC, B2, 2, 0, 0);   // R1 new root captured
    walk(32'h0080_0FFF, B1, 4, 1, 0);   // R4 fault again back to back
    walk(32'hFFFF_FFFF, B1, 1, 1, 0);
    repeat (3) @(negedge clk);
    chk(req_ready === 1'b1, "R1", "idle after walks", 32'(req_ready), 1);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule